// File: doc/BRIEF.md
# Lockable Bus Watchdog Timer

This peripheral sits on an APB bus and watches for a stalled system. A down-counter runs on qualified clock ticks. When it runs out, it raises an interrupt and reloads. If it runs out a second time before software clears the interrupt, it raises a reset request. A key-protected lock blocks stray writes from reconfiguring the timer. In the base build, a test override can drive both outputs directly from a register. A read-only identification bank sits at the top of the 4 KB window.

A build parameter selects an alternate variant. That variant has a different identification bank and no test override. It decodes an extra dummy test register. Its control register freezes once the interrupt enable is set, and only a reset releases it.

The timeout state machine has three states. QUIET means the flag is clear. PENDING means the flag is set. BITE means the reset request is asserted, and it is terminal until reset. The transitions are:
- QUIET→PENDING on an expiry.
- PENDING→QUIET on an interrupt-clear write that arrives without a same-cycle expiry.
- PENDING→PENDING on an expiry while reset enable is off.
- PENDING→BITE on an expiry while reset enable is on.
- BITE→BITE always.

Top module: `guard_timer_apb`

## Requirements
- R1: After reset the block is unlocked. The load word and the count both read 0xFFFFFFFF. Control reads 0. The flag is clear, and both outputs are low.
- R2: A write at 0x000 stores the load word (read back at 0x000) and also loads the counter. The counter reads at 0x004.
- R3: The count advances only while control bit 0 is set and tick_en is high. Each such cycle decrements a nonzero count. At zero, the cycle reloads the load word instead and sets the raw flag, which reads at 0x010 bit 0.
- R4: 0x014 bit 0 reads the raw flag ANDed with control bit 0. With the override off, wdog_irq follows the same value.
- R5: A write to 0x00C with any data clears a pending flag. If an expiry happens in the same cycle, the expiry wins.
- R6: An expiry while the flag is set and control bit 1 is set raises wdog_rst. It stays high until presetn, and the flag stays set regardless of clear writes.
- R7: A write at 0xC00 of 0x1ACCE551 unlocks the block, and any other value locks it. 0xC00 bit 0 reads 1 when locked. While locked, writes to every other offset are ignored.
- R8: In the base build, 0xF00 bit 0 is a readable override enable. While it is set, wdog_irq equals 0xF04 bit 0 and wdog_rst equals 0xF04 bit 1. 0xF04 is write-only.
- R9: The identification bank is twelve words from 0xFD0 to 0xFFC, each holding one byte.
  - Base build: 04,00,00,00,24,B8,1B,00,0D,F0,05,B1.
  - Alternate build: 00,00,00,00,05,18,18,01,0D,F0,05,B1.
- R10: In the alternate build, 0xF00 and 0xF04 read 0 and ignore writes, so the override never takes effect.
- R11: Offset 0x418 reads 0 and ignores writes in both builds. It is decoded only in the alternate build.
- R12: In the alternate build, control writes are ignored once control bit 0 is 1. In the base build, control is always writable when unlocked.
- R13: Reads of 0x00C, 0xF04 and any undecoded offset return 0. Writes to the read-only offsets 0x004, 0x010 and 0x014 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | Write when high |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from paddr |
| tick_en | input | 1 | Count qualifier |
| wdog_irq | output | 1 | Interrupt request |
| wdog_rst | output | 1 | Reset request |

## Verification
The bench drives two copies of the block from one bus: one built with ALT_VARIANT=0 and one with ALT_VARIANT=1. Every write therefore exercises both builds in the same cycle.

The shared stimulus is what makes the variant differences visible. The same control write arms reset enable in one copy and is discarded by the other. Test-override writes take effect in one copy and vanish in the other. The two copies return different identification bytes.

A second reset lets the alternate copy accept control writes again. This exercises the path where its freeze is released only by reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned AW = 12;
    localparam int unsigned DW = 32;

    localparam logic [AW-1:0] OFS_LOAD  = 12'h000;
    localparam logic [AW-1:0] OFS_VALUE = 12'h004;
    localparam logic [AW-1:0] OFS_CTRL  = 12'h008;
    localparam logic [AW-1:0] OFS_ICLR  = 12'h00C;
    localparam logic [AW-1:0] OFS_RAW   = 12'h010;
    localparam logic [AW-1:0] OFS_MSK   = 12'h014;
    localparam logic [AW-1:0] OFS_TEST  = 12'h418;
    localparam logic [AW-1:0] OFS_LOCK  = 12'hC00;
    localparam logic [AW-1:0] OFS_ITEN  = 12'hF00;
    localparam logic [AW-1:0] OFS_ITOUT = 12'hF04;
    localparam logic [AW-1:0] OFS_ID0   = 12'hFD0;
    localparam int unsigned   ID_WORDS  = 12;

    localparam logic [DW-1:0] UNLOCK_KEY = 32'h1ACCE551;

    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_PENDING = 2'd1,
        ST_BITE    = 2'd2
    } wd_state_e;

    // Identification byte for word idx of the bank, chosen by build variant.
    function automatic logic [7:0] id_byte(input logic alt, input int unsigned idx);
        logic [7:0] b;
        case (idx)
            0:       b = alt ? 8'h00 : 8'h04;
            4:       b = alt ? 8'h05 : 8'h24;
            5:       b = alt ? 8'h18 : 8'hB8;
            6:       b = alt ? 8'h18 : 8'h1B;
            7:       b = alt ? 8'h01 : 8'h00;
            8:       b = 8'h0D;
            9:       b = 8'hF0;
            10:      b = 8'h05;
            11:      b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld_wr,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    assign expire = tick && (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '1;
        else if (ld_wr)   count <= ld_val;
        else if (expire)  count <= reload_val;
        else if (tick)    count <= count - ONE;
    end

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !ld_wr |=> count == $past(reload_val));
    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && count != '0 && !ld_wr |=> count == $past(count) - ONE);
    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |=> count == $past(ld_val));
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_req,
    input  logic bite_en,
    output logic raw_flag,
    output logic bite
);
    wd_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_QUIET:   if (expire) state_nx = ST_PENDING;
            ST_PENDING: begin
                if (expire && bite_en) state_nx = ST_BITE;
                else if (expire)       state_nx = ST_PENDING;
                else if (clr_req)      state_nx = ST_QUIET;
            end
            ST_BITE:    state_nx = ST_BITE;
            default:    state_nx = ST_QUIET;
        endcase
    end

    always_comb begin
        raw_flag = (state == ST_PENDING) || (state == ST_BITE);
        bite     = (state == ST_BITE);
    end

    // R6
    bite_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bite |=> bite && raw_flag);
    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_flag && !bite && clr_req && !expire |=> !raw_flag);
    // R3
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw_flag);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter bit          ALT = 1'b0,
    parameter int unsigned W   = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    input  logic [W-1:0]  count,
    input  logic          raw_flag,
    output logic [DW-1:0] prdata,
    output logic [W-1:0]  load_q,
    output logic          ien,
    output logic          ren,
    output logic          ld_wr,
    output logic          clr_wr,
    output logic          ovr_en,
    output logic          ovr_irq,
    output logic          ovr_rst
);
    localparam int unsigned IDX_W = $clog2(ID_WORDS) + 1;

    logic wr_en, acc, locked, ctrl_ok;

    assign wr_en  = psel && penable && pwrite;
    assign acc    = wr_en && !locked;
    assign ld_wr  = acc && (paddr == OFS_LOAD);
    assign clr_wr = acc && (paddr == OFS_ICLR);

    generate
        if (ALT) begin : g_alt
            assign ctrl_ok = !ien;
            assign ovr_en  = 1'b0;
            assign ovr_irq = 1'b0;
            assign ovr_rst = 1'b0;
        end else begin : g_base
            logic it_en_q;
            logic [1:0] it_out_q;
            assign ctrl_ok = 1'b1;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    it_en_q  <= 1'b0;
                    it_out_q <= 2'b00;
                end else begin
                    if (acc && paddr == OFS_ITEN)  it_en_q  <= pwdata[0];
                    if (acc && paddr == OFS_ITOUT) it_out_q <= pwdata[1:0];
                end
            end
            assign ovr_en  = it_en_q;
            assign ovr_irq = it_out_q[0];
            assign ovr_rst = it_out_q[1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '1;
            ien    <= 1'b0;
            ren    <= 1'b0;
            locked <= 1'b0;
        end else begin
            if (ld_wr) load_q <= pwdata[W-1:0];
            if (acc && paddr == OFS_CTRL && ctrl_ok) begin
                ien <= pwdata[0];
                ren <= pwdata[1];
            end
            if (wr_en && paddr == OFS_LOCK) locked <= (pwdata != UNLOCK_KEY);
        end
    end

    logic [IDX_W-1:0] id_idx;
    logic             id_hit;
    logic [AW-1:0]    id_ofs;
    assign id_ofs = paddr - OFS_ID0;
    assign id_hit = (paddr >= OFS_ID0) && (paddr[1:0] == 2'b00);
    assign id_idx = IDX_W'(id_ofs >> 2);

    always_comb begin
        prdata = '0;
        if (id_hit) begin
            prdata = DW'(id_byte(ALT, int'(id_idx)));
        end else begin
            case (paddr)
                OFS_LOAD:  prdata = DW'(load_q);
                OFS_VALUE: prdata = DW'(count);
                OFS_CTRL:  prdata = DW'({ren, ien});
                OFS_RAW:   prdata = DW'(raw_flag);
                OFS_MSK:   prdata = DW'(raw_flag && ien);
                OFS_LOCK:  prdata = DW'(locked);
                OFS_ITEN:  prdata = DW'(ovr_en);
                default:   prdata = '0;
            endcase
        end
    end

    // R7
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked && wr_en && paddr != OFS_LOCK |=> $stable(load_q) && $stable(ien) && $stable(ren));
    // R7
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && paddr == OFS_LOCK && pwdata == UNLOCK_KEY |=> prdata == '0 || paddr != OFS_LOCK);

    generate
        if (ALT) begin : g_alt_chk
            // R12
            ctrl_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ien |=> ien && $stable(ren));
        end
    endgenerate
endmodule

// File: rtl/guard_timer_apb.sv
module guard_timer_apb
    import wdt_pkg::*;
#(
    parameter bit          ALT_VARIANT = 1'b0,
    parameter int unsigned CNT_W       = 32
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [11:0]   paddr,
    input  logic [31:0]   pwdata,
    output logic [31:0]   prdata,
    input  logic          tick_en,
    output logic          wdog_irq,
    output logic          wdog_rst
);
    logic [CNT_W-1:0] count, load_q;
    logic ien, ren, ld_wr, clr_wr, ovr_en, ovr_irq, ovr_rst;
    logic expire, raw_flag, bite;

    wdt_regs #(.ALT(ALT_VARIANT), .W(CNT_W)) u_regs (
        .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .count(count),
        .raw_flag(raw_flag), .prdata(prdata), .load_q(load_q), .ien(ien),
        .ren(ren), .ld_wr(ld_wr), .clr_wr(clr_wr), .ovr_en(ovr_en),
        .ovr_irq(ovr_irq), .ovr_rst(ovr_rst)
    );

    wdt_downcount #(.W(CNT_W)) u_cnt (
        .clk(pclk), .rst_n(presetn), .tick(tick_en && ien), .ld_wr(ld_wr),
        .ld_val(pwdata[CNT_W-1:0]), .reload_val(load_q), .count(count),
        .expire(expire)
    );

    wdt_fsm u_fsm (
        .clk(pclk), .rst_n(presetn), .expire(expire), .clr_req(clr_wr),
        .bite_en(ren), .raw_flag(raw_flag), .bite(bite)
    );

    always_comb begin
        wdog_irq = ovr_en ? ovr_irq : (raw_flag && ien);
        wdog_rst = ovr_en ? ovr_rst : bite;
    end

    // R8
    ovr_chk: assert property (@(posedge pclk) disable iff (!presetn)
        ovr_en |-> wdog_irq == ovr_irq && wdog_rst == ovr_rst);
    // R4
    irq_src_chk: assert property (@(posedge pclk) disable iff (!presetn)
        !ovr_en && !raw_flag |-> !wdog_irq);
endmodule

// File: tb/guard_timer_apb_tb_top.sv
`timescale 1ns/1ps
module guard_timer_apb_tb_top;
    localparam logic [31:0] KEY = 32'h1ACCE551;

    logic clk = 1'b0;
    logic presetn = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0, tick_en = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] rd [2];
    logic irq [2];
    logic rst [2];
    int compared = 0, mismatched = 0, cyc = 0;

    always #2.5 clk = ~clk;

    guard_timer_apb #(.ALT_VARIANT(1'b0)) dut_i (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(rd[0]),
        .tick_en(tick_en), .wdog_irq(irq[0]), .wdog_rst(rst[0]));
    guard_timer_apb #(.ALT_VARIANT(1'b1)) dut_alt_i (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(rd[1]),
        .tick_en(tick_en), .wdog_irq(irq[1]), .wdog_rst(rst[1]));

    // Behavioural reference, one slot per build (0 base, 1 alternate).
    logic [31:0] m_load [2];
    logic [31:0] m_cnt [2];
    logic [1:0]  m_ctrl [2];
    logic [1:0]  m_itout [2];
    logic        m_lock [2];
    logic        m_iten [2];
    int          m_st [2];

    function automatic logic [7:0] ref_id(int v, int i);
        logic [7:0] base_t [12] = '{8'h04,8'h00,8'h00,8'h00,8'h24,8'hB8,8'h1B,8'h00,8'h0D,8'hF0,8'h05,8'hB1};
        logic [7:0] alt_t  [12] = '{8'h00,8'h00,8'h00,8'h00,8'h05,8'h18,8'h18,8'h01,8'h0D,8'hF0,8'h05,8'hB1};
        return (v == 0) ? base_t[i] : alt_t[i];
    endfunction

    function automatic logic [31:0] ref_read(int v, logic [11:0] a);
        if (a >= 12'hFD0 && a[1:0] == 0) return {24'h0, ref_id(v, (int'(a) - 'hFD0) / 4)};
        case (a)
            12'h000: return m_load[v];
            12'h004: return m_cnt[v];
            12'h008: return {30'h0, m_ctrl[v]};
            12'h010: return {31'h0, m_st[v] != 0};
            12'h014: return {31'h0, m_st[v] != 0 && m_ctrl[v][0]};
            12'hC00: return {31'h0, m_lock[v]};
            12'hF00: return {31'h0, m_iten[v]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(int v, logic [11:0] a);
        if (a >= 12'hFD0) return "R9";
        case (a)
            12'h000, 12'h004: return "R2";
            12'h008: return "R12";
            12'h010: return "R3";
            12'h014: return "R4";
            12'hC00: return "R7";
            12'hF00, 12'hF04: return (v == 0) ? "R8" : "R10";
            12'h418: return "R11";
            default: return "R13";
        endcase
    endfunction

    always @(posedge clk or negedge presetn) begin
        if (!presetn) begin
            for (int v = 0; v < 2; v++) begin
                m_load[v] = '1; m_cnt[v] = '1; m_ctrl[v] = 0; m_itout[v] = 0;
                m_lock[v] = 0; m_iten[v] = 0; m_st[v] = 0;
            end
        end else begin
            for (int v = 0; v < 2; v++) begin
                bit wr, acc, tick, ex;
                wr   = psel && penable && pwrite;
                acc  = wr && !m_lock[v];
                tick = tick_en && m_ctrl[v][0];
                ex   = tick && m_cnt[v] == 0;
                if (m_st[v] == 0) begin
                    if (ex) m_st[v] = 1;
                end else if (m_st[v] == 1) begin
                    if (ex && m_ctrl[v][1]) m_st[v] = 2;
                    else if (!ex && acc && paddr == 12'h00C) m_st[v] = 0;
                end
                if (acc && paddr == 12'h000) m_cnt[v] = pwdata;
                else if (ex) m_cnt[v] = m_load[v];
                else if (tick) m_cnt[v] = m_cnt[v] - 1;
                if (acc && paddr == 12'h000) m_load[v] = pwdata;
                if (acc && paddr == 12'h008 && !(v == 1 && m_ctrl[v][0])) m_ctrl[v] = pwdata[1:0];
                if (acc && v == 0 && paddr == 12'hF00) m_iten[v] = pwdata[0];
                if (acc && v == 0 && paddr == 12'hF04) m_itout[v] = pwdata[1:0];
                if (wr && paddr == 12'hC00) m_lock[v] = (pwdata != KEY);
            end
        end
    end

    task automatic cmp(logic [31:0] act, logic [31:0] exp, string tag, int v);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s build%0d addr=%h actual=%h expected=%h", tag, v, paddr, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (presetn) begin
            for (int v = 0; v < 2; v++) begin
                cmp(32'(rd[v]), ref_read(v, paddr), tag_of(v, paddr), v);
                cmp(32'(irq[v]), 32'(m_iten[v] ? m_itout[v][0] : (m_st[v] != 0 && m_ctrl[v][0])), "R4", v);
                cmp(32'(rst[v]), 32'(m_iten[v] ? m_itout[v][1] : (m_st[v] == 2)), "R6", v);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            mismatched++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic apb_wr(logic [11:0] a, logic [31:0] d);
        @(posedge clk); #1;
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(posedge clk); #1; penable = 1;
        @(posedge clk); #1; psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic probe(logic [11:0] a, string tag);
        @(posedge clk); #1; paddr = a;
        @(negedge clk);
        for (int v = 0; v < 2; v++) cmp(rd[v], ref_read(v, a), tag, v);
    endtask

    task automatic fixed(logic [11:0] a, logic [31:0] e0, logic [31:0] e1, string tag);
        @(posedge clk); #1; paddr = a;
        @(negedge clk);
        cmp(rd[0], e0, tag, 0);
        cmp(rd[1], e1, tag, 1);
    endtask

    task automatic do_reset();
        @(posedge clk); #1; presetn = 0; tick_en = 0;
        repeat (3) @(posedge clk);
        #1; presetn = 1;
    endtask

    initial begin
        do_reset();
        // R1 reset state from fixed values
        fixed(12'h000, 32'hFFFFFFFF, 32'hFFFFFFFF, "R1");
        fixed(12'h004, 32'hFFFFFFFF, 32'hFFFFFFFF, "R1");
        fixed(12'h008, 0, 0, "R1");
        fixed(12'hC00, 0, 0, "R1");
        fixed(12'h010, 0, 0, "R1");
        // R2 R3 counting and expiry
        apb_wr(12'h000, 5);
        apb_wr(12'h008, 1);
        tick_en = 1;
        for (int i = 0; i < 10; i++) probe(12'h004, "R3");
        probe(12'h010, "R3");
        probe(12'h014, "R4");
        // R5 clear
        apb_wr(12'h00C, 32'hDEAD);
        probe(12'h010, "R5");
        // gapped ticks
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1; tick_en = i[0]; paddr = 12'h004;
        end
        tick_en = 1;
        // R12: base arms reset enable, alternate drops the write
        apb_wr(12'h008, 3);
        fixed(12'h008, 3, 1, "R12");
        for (int i = 0; i < 30; i++) probe(12'h010, "R6");
        apb_wr(12'h00C, 0);
        probe(12'h010, "R6");
        // R7 lock
        apb_wr(12'hC00, 0);
        fixed(12'hC00, 1, 1, "R7");
        apb_wr(12'h000, 9);
        probe(12'h000, "R7");
        apb_wr(12'hC00, KEY);
        fixed(12'hC00, 0, 0, "R7");
        // R8 R10 override
        apb_wr(12'hF04, 2);
        apb_wr(12'hF00, 1);
        fixed(12'hF00, 1, 0, "R8");
        probe(12'hF04, "R10");
        apb_wr(12'hF04, 1);
        probe(12'hF04, "R8");
        apb_wr(12'hF00, 0);
        // R11 test word
        apb_wr(12'h418, 32'hFFFFFFFF);
        fixed(12'h418, 0, 0, "R11");
        // R9 identification
        for (int i = 0; i < 12; i++) probe(12'(12'hFD0 + 4 * i), "R9");
        fixed(12'hFE4, 32'hB8, 32'h18, "R9");
        // R13 undecoded and read-only
        probe(12'h100, "R13");
        apb_wr(12'h004, 7);
        apb_wr(12'h014, 1);
        probe(12'h004, "R13");
        probe(12'h00C, "R13");
        // second life: alternate control writable again after reset
        do_reset();
        tick_en = 1;
        apb_wr(12'h008, 2);
        probe(12'h004, "R3");
        apb_wr(12'h008, 0);
        fixed(12'h008, 0, 0, "R12");
        apb_wr(12'h000, 2);
        apb_wr(12'h008, 3);
        for (int i = 0; i < 12; i++) probe(12'h014, "R6");
        apb_wr(12'h00C, 0);
        probe(12'h010, "R6");
        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule